// File: doc/BRIEF.md
# Cache Enable Sequencer

This block brings an external cache controller from the disabled state to the enabled state. It does this by writing that controller's control register in a fixed order. A one-cycle start pulse carries the 32-bit target configuration. The sequencer first clears the bits that must not be set early and writes that masked value. It then sets an extra bit that is reserved in normal operation, and then turns on the cache clock.

Next it starts a global invalidate and reads the register back every cycle until the invalidate bit clears. It then gates the cache clock off and waits a settling interval. After that it turns the clock and the enable bit on together in one write, waits a second settling interval, and pulses done.

Wait intervals and the poll limit are counted in core clock cycles. If the invalidate never completes within the poll limit, the sequence stops and an error flag is raised. The block does not interpret any configuration field. The only bits it touches are the enable, invalidate, parity-enable, clock-enable, reserved and extra bits, and their positions are parameters.

Top module: `cache_en_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, wr_o and rd_o are all low, and no write or read is issued while the block is idle.
- R2: The cycle after an accepted start_i, a write carries cfg_i with these bits cleared: enable (EN_BIT, default 31), parity-enable (PE_BIT, default 30), invalidate (INV_BIT, default 10), clock-enable (CLK_BIT, default 3), and every bit of RSVD_MASK (default 32'h07F0_0000). This cleared value is called the base.
- R3: In the next two consecutive cycles the block writes the base OR EXTRA_MASK (default 32'h0400_0000), and then that value with the clock-enable bit added.
- R4: In the next cycle it writes the previous value with the invalidate bit added. From the following cycle on it asserts rd_o every cycle until a sampled rd_data_i has the invalidate bit at zero.
- R5: In the cycle after the read that shows the invalidate bit clear, the block writes base OR EXTRA_MASK, which has clock-enable off.
- R6: The block then stays silent for SETTLE_CYC cycles. In the next cycle it writes base OR EXTRA_MASK with both the enable and clock-enable bits set, and the invalidate bit clear.
- R7: SETTLE_CYC cycles after that final write, done_o is high for exactly one cycle, with busy_o low. busy_o is high from the cycle after an accepted start until then.
- R8: start_i is ignored while busy_o is high. Neither the written values nor the completion are changed by it.
- R9: If POLL_LIMIT consecutive reads all show the invalidate bit set, the block raises err_o, returns to idle without further writes and without done_o, and keeps err_o set until the next accepted start.
- R10: No written value has the parity-enable bit set, and wr_o and rd_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| cfg_i | input | DW | Target configuration word, sampled with start_i |
| wr_o | output | 1 | Control register write strobe |
| wr_data_o | output | DW | Control register write data |
| rd_o | output | 1 | Control register read strobe (invalidate poll) |
| rd_data_i | input | DW | Control register readback, sampled while rd_o is high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Invalidate poll timed out |

## Verification
The hardest cases to reach are the edges of the poll loop. One is an invalidate that clears on exactly the last allowed read. The other is an invalidate that never clears, which must end in the error path rather than the final enable. The bench models the external register. It holds the invalidate bit high for a programmed number of reads, from zero up to POLL_LIMIT-1, or holds it high forever. Each of these delays is swept across several configuration words, and the timeout run is followed by a normal run to show that the error flag clears.

// File: rtl/cache_en_seq_pkg.sv
`timescale 1ns/1ps
package cache_en_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_MASK   = 4'd1,
    ST_EXTRA  = 4'd2,
    ST_CLKON  = 4'd3,
    ST_INV    = 4'd4,
    ST_POLL   = 4'd5,
    ST_CLKOFF = 4'd6,
    ST_WAIT1  = 4'd7,
    ST_FINAL  = 4'd8,
    ST_WAIT2  = 4'd9
  } seq_st_e;
endpackage

// File: rtl/ces_timer.sv
`timescale 1ns/1ps
module ces_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/ces_word.sv
`timescale 1ns/1ps
module ces_word
  import cache_en_seq_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          EN_BIT     = 31,
  parameter int          INV_BIT    = 10,
  parameter int          CLK_BIT    = 3,
  parameter logic [DW-1:0] EXTRA_MASK = 32'h0400_0000
) (
  input  seq_st_e        st_i,
  input  logic [DW-1:0]  base_i,
  output logic [DW-1:0]  word_o
);
  localparam logic [DW-1:0] EN_M  = DW'(1) << EN_BIT;
  localparam logic [DW-1:0] INV_M = DW'(1) << INV_BIT;
  localparam logic [DW-1:0] CLK_M = DW'(1) << CLK_BIT;

  logic [DW-1:0] with_extra;
  assign with_extra = base_i | EXTRA_MASK;

  always_comb begin
    unique case (st_i)
      ST_MASK:   word_o = base_i;
      ST_EXTRA:  word_o = with_extra;
      ST_CLKON:  word_o = with_extra | CLK_M;
      ST_INV:    word_o = with_extra | CLK_M | INV_M;
      ST_CLKOFF: word_o = with_extra;
      ST_FINAL:  word_o = with_extra | CLK_M | EN_M;
      default:   word_o = '0;
    endcase
  end
endmodule

// File: rtl/cache_en_seq.sv
`timescale 1ns/1ps
module cache_en_seq
  import cache_en_seq_pkg::*;
#(
  parameter int            DW         = 32,
  parameter int            EN_BIT     = 31,
  parameter int            PE_BIT     = 30,
  parameter int            INV_BIT    = 10,
  parameter int            CLK_BIT    = 3,
  parameter logic [DW-1:0] RSVD_MASK  = 32'h07F0_0000,
  parameter logic [DW-1:0] EXTRA_MASK = 32'h0400_0000,
  parameter int            SETTLE_CYC = 100,
  parameter int            POLL_LIMIT = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] cfg_i,
  output logic          wr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam logic [DW-1:0] CLEAR_M = (DW'(1) << EN_BIT) | (DW'(1) << PE_BIT) |
                                      (DW'(1) << INV_BIT) | (DW'(1) << CLK_BIT) |
                                      RSVD_MASK;

  seq_st_e       st_q, st_d;
  logic [DW-1:0] base_q;
  logic          base_en;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          in_wait, settle_hit, poll_hit;
  logic          accept;

  assign accept  = (st_q == ST_IDLE) && start_i;
  assign in_wait = (st_q == ST_WAIT1) || (st_q == ST_WAIT2);
  assign base_en = accept;

  ces_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .clr_i(!in_wait), .en_i(in_wait), .hit_o(settle_hit)
  );

  ces_timer #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr_i(st_q != ST_POLL), .en_i(st_q == ST_POLL),
    .hit_o(poll_hit)
  );

  ces_word #(
    .DW(DW), .EN_BIT(EN_BIT), .INV_BIT(INV_BIT), .CLK_BIT(CLK_BIT),
    .EXTRA_MASK(EXTRA_MASK)
  ) u_word (
    .st_i(st_q), .base_i(base_q), .word_o(wr_data_o)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    err_d  = err_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d  = ST_MASK;
        err_d = 1'b0;
      end
      ST_MASK:   st_d = ST_EXTRA;
      ST_EXTRA:  st_d = ST_CLKON;
      ST_CLKON:  st_d = ST_INV;
      ST_INV:    st_d = ST_POLL;
      ST_POLL: begin
        if (!rd_data_i[INV_BIT]) st_d = ST_CLKOFF;
        else if (poll_hit) begin
          st_d  = ST_IDLE;
          err_d = 1'b1;
        end
      end
      ST_CLKOFF: st_d = ST_WAIT1;
      ST_WAIT1:  if (settle_hit) st_d = ST_FINAL;
      ST_FINAL:  st_d = ST_WAIT2;
      ST_WAIT2: if (settle_hit) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default:   st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= cfg_i & ~CLEAR_M;
  end

  assign wr_o   = (st_q == ST_MASK) || (st_q == ST_EXTRA) || (st_q == ST_CLKON) ||
                  (st_q == ST_INV)  || (st_q == ST_CLKOFF) || (st_q == ST_FINAL);
  assign rd_o   = (st_q == ST_POLL);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/ces_chk.sv
`timescale 1ns/1ps
module ces_chk #(
  parameter int DW      = 32,
  parameter int EN_BIT  = 31,
  parameter int PE_BIT  = 30,
  parameter int INV_BIT = 10,
  parameter int CLK_BIT = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_o,
  input logic [DW-1:0] wr_data_o,
  input logic          rd_o,
  input logic [DW-1:0] rd_data_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!wr_o && !rd_o));

  assert_poll_follows_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && wr_data_o[INV_BIT]) |=> rd_o);

  assert_clkoff_after_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o && !rd_data_i[INV_BIT]) |=> (wr_o && !wr_data_o[CLK_BIT] && !wr_data_o[EN_BIT]));

  assert_final_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && wr_data_o[EN_BIT]) |-> (wr_data_o[CLK_BIT] && !wr_data_o[INV_BIT]));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_err_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_o && done_o));

  assert_no_parity_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_o && wr_data_o[PE_BIT]));

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_o && rd_o));
endmodule

bind cache_en_seq ces_chk #(
  .DW(DW), .EN_BIT(EN_BIT), .PE_BIT(PE_BIT), .INV_BIT(INV_BIT), .CLK_BIT(CLK_BIT)
) u_ces_chk (
  .clk(clk), .rst_n(rst_n), .wr_o(wr_o), .wr_data_o(wr_data_o), .rd_o(rd_o),
  .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_cache_en_seq.sv
`timescale 1ns/1ps
module tb_cache_en_seq;
  localparam int DW = 32, EN = 31, PE = 30, INV = 10, CK = 3;
  localparam logic [31:0] RSVD = 32'h07F0_0000, EXTRA = 32'h0400_0000;
  localparam int SETTLE = 12, PLIM = 20;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] cfg = '0;
  logic wr, rd, busy, done, err;
  logic [31:0] wdata, rdata;

  always #2 clk = ~clk;

  cache_en_seq #(
    .DW(DW), .EN_BIT(EN), .PE_BIT(PE), .INV_BIT(INV), .CLK_BIT(CK),
    .RSVD_MASK(RSVD), .EXTRA_MASK(EXTRA), .SETTLE_CYC(SETTLE), .POLL_LIMIT(PLIM)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_i(cfg), .wr_o(wr),
    .wr_data_o(wdata), .rd_o(rd), .rd_data_i(rdata), .busy_o(busy),
    .done_o(done), .err_o(err)
  );

  // external register model and event log
  int poll_delay = 0;
  logic stuck = 1'b0;
  int inv_left, cyc, nwr, nrd, ndone, done_t;
  logic [31:0] ext_reg;
  logic [31:0] log_d [512];
  int          log_t [512];

  assign rdata = {ext_reg[31:INV+1], (stuck || inv_left != 0), ext_reg[INV-1:0]};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0; nwr <= 0; nrd <= 0; ndone <= 0; done_t <= 0;
      inv_left <= 0; ext_reg <= '0;
    end else begin
      cyc <= cyc + 1;
      if (wr) begin
        log_d[nwr] <= wdata;
        log_t[nwr] <= cyc;
        nwr <= nwr + 1;
        ext_reg <= wdata;
        if (wdata[INV]) inv_left <= poll_delay;
      end
      if (rd) begin
        nrd <= nrd + 1;
        if (inv_left > 0) inv_left <= inv_left - 1;
      end
      if (done) begin
        ndone <= ndone + 1;
        done_t <= cyc;
      end
    end
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [31:0] c, input int dly, input logic stk, input logic mid);
    int w0, r0, d0;
    logic [31:0] b, e1;
    logic [31:0] e [6];
    b  = c & ~((32'd1 << EN) | (32'd1 << PE) | (32'd1 << INV) | (32'd1 << CK) | RSVD);
    e1 = b | EXTRA;
    e[0] = b; e[1] = e1; e[2] = e1 | (32'd1 << CK); e[3] = e[2] | (32'd1 << INV);
    e[4] = e1; e[5] = e1 | (32'd1 << CK) | (32'd1 << EN);
    @(negedge clk);
    poll_delay = dly; stuck = stk;
    w0 = nwr; r0 = nrd; d0 = ndone;
    start = 1'b1; cfg = c;
    @(negedge clk);
    start = 1'b0; cfg = ~c;
    chk("R7 busy after start", busy, 1);
    if (mid) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_idle();
    if (stk) begin
      chk("R9 writes before abort", nwr - w0, 4);
      chk("R9 reads until timeout", nrd - r0, PLIM);
      chk("R9 err raised", err, 1);
      chk("R9 no done", ndone - d0, 0);
      chk("R9 invalidate word", log_d[w0+3], e[3]);
    end else begin
      chk("R8 write count", nwr - w0, 6);
      chk("R2 masked word", log_d[w0], e[0]);
      chk("R3 extra word", log_d[w0+1], e[1]);
      chk("R3 clock-on word", log_d[w0+2], e[2]);
      chk("R4 invalidate word", log_d[w0+3], e[3]);
      chk("R5 clock-off word", log_d[w0+4], e[4]);
      chk("R6 final word", log_d[w0+5], e[5]);
      chk("R3 back-to-back", log_t[w0+3] - log_t[w0], 3);
      chk("R4 poll reads", nrd - r0, dly + 1);
      chk("R5 clock-off timing", log_t[w0+4] - log_t[w0+3], dly + 2);
      chk("R6 settle gap", log_t[w0+5] - log_t[w0+4], SETTLE + 1);
      chk("R7 done timing", done_t - log_t[w0+5], SETTLE + 1);
      chk("R7 one done", ndone - d0, 1);
      chk("R10 parity clear", {31'd0, log_d[w0+5][PE]}, 0);
      chk("R9 err low", err, 0);
    end
    chk("R7 idle at end", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hA5A5_A5A5;
    pats[3] = 32'h5A5A_5A5A; pats[4] = 32'h8000_0408; pats[5] = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk("R1 busy reset", busy, 0);
    chk("R1 done reset", done, 0);
    chk("R1 err reset", err, 0);
    chk("R1 wr reset", wr, 0);
    chk("R1 rd reset", rd, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle no writes", nwr, 0);
    for (int p = 0; p < 6; p++) begin
      run(pats[p], 0, 1'b0, 1'b0);
      run(pats[p], 1, 1'b0, 1'b0);
      run(pats[p], 3, 1'b0, 1'b0);
      run(pats[p], PLIM - 1, 1'b0, 1'b0);
    end
    run(32'hDEAD_BEEF, 2, 1'b0, 1'b1);
    run(32'hFFFF_FFFF, 0, 1'b1, 1'b0);
    run(32'h0F0F_0F0F, 5, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule